// File: doc/BRIEF.md
# Register-Indirect Effective Address Stage

This block is one pipeline stage that turns the operand-addressing fields of a decoded instruction into a 32-bit effective address. Each request carries the two-bit addressing mode, the three-bit register/memory selector, the scale-index-base byte, and a 32-bit displacement word. The stage reads up to two values from a flat view of the eight 32-bit general registers, adds the scaled index, the base and the displacement, and hands the result on one cycle later. When the mode names a register operand instead of memory, the stage flags that and passes the register number through with a zero address.

The irregular encodings are all handled: the slot that would be a plain base-pointer access without displacement instead means "absolute 32-bit displacement". Selector 100 escapes to the scale-index-base byte. In that byte, index code 100 means "no index", and base code 101 in mode 00 means "no base, 32-bit displacement".

Both sides use a valid/ready handshake. A request moves in when `in_valid` and `in_ready` are high on the same rising edge. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. A result stays on the outputs, unchanged, until `out_ready` takes it. Register contents are sampled on the edge that accepts a request.

Top module: `agu_stage`

## Requirements
- R1: Mode 00 with selector other than 100 or 101 gives the address equal to the register whose number is the selector (registers 0..7 at `gpr_flat[32*n +: 32]`).
- R2: Mode 01 adds the low byte of `in_disp`, sign-extended, to the selected register; bits 31:8 of `in_disp` have no effect.
- R3: Mode 10 adds all 32 bits of `in_disp` to the selected register.
- R4: Mode 00 with selector 101 gives an address equal to `in_disp`, whatever register 5 holds.
- R5: Mode 11 sets `out_is_reg` to 1 and `out_addr` to zero; for modes 00/01/10, `out_is_reg` is 0. In every case `out_rm` carries the selector.
- R6: Selector 100 in modes 00/01/10 uses the `in_sib` byte (scale in bits 7:6, index in bits 5:3, base in bits 2:0). The address is base register + index register × 2^scale + displacement. The displacement is none for mode 00, a sign-extended byte for mode 01, and the full word for mode 10.
- R7: Index code 100 in the scale-index-base byte contributes no index term, whatever the scale.
- R8: Base code 101 with mode 00 drops the base register and adds the full 32-bit displacement. With modes 01/10, base code 101 uses register 5 as usual.
- R9: All address arithmetic wraps modulo 2^32.
- R10: `in_ready` equals (no result held) or `out_ready`. A result appears on the outputs the cycle after acceptance. While `out_valid` is high and `out_ready` is low, every output stays unchanged. Results leave in the order they arrived.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Stage can take a request |
| in_mode | input | 2 | Addressing mode field |
| in_rm | input | 3 | Register/memory selector field |
| in_sib | input | 8 | Scale-index-base byte |
| in_disp | input | 32 | Displacement word (low byte used in mode 01) |
| gpr_flat | input | 256 | Eight general registers, register n at bits 32n+31:32n |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Effective address (zero for register operands) |
| out_is_reg | output | 1 | Operand is a register, not memory |
| out_rm | output | 3 | Selector field of the request |

## Verification
The functions that meet in one cycle are the intake of a new request and the release of the held result. When both handshakes fire on the same edge, the output register must reload, not hold, with no bubble and no duplicate. The bench provokes this by keeping `in_valid` mostly high while toggling `out_ready` at random. Each accepted request is matched, in order, against a scoreboard of model addresses. Any stalled cycle is checked for outputs identical to those of the cycle before.

// File: rtl/agu_pkg.sv
package agu_pkg;

  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_BYTE   = 2'b01;
  localparam logic [1:0] MODE_WORD   = 2'b10;
  localparam logic [1:0] MODE_REG    = 2'b11;
  localparam logic [2:0] RM_ESCAPE   = 3'b100;
  localparam logic [2:0] CODE_NOBASE = 3'b101;
  localparam logic [2:0] CODE_NOIDX  = 3'b100;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } disp_kind_e;

  typedef struct packed {
    logic       is_reg;
    logic       base_en;
    logic [2:0] base_sel;
    logic       idx_en;
    logic [2:0] idx_sel;
    logic [1:0] scale;
    disp_kind_e dk;
  } agu_ctl_t;

endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [2:0] rm,
  input  logic [7:0] sib,
  output agu_ctl_t   ctl
);

  logic [1:0] sib_scale;
  logic [2:0] sib_idx;
  logic [2:0] sib_base;
  logic       use_sib;

  assign sib_scale = sib[7:6];
  assign sib_idx   = sib[5:3];
  assign sib_base  = sib[2:0];
  assign use_sib   = (mode != MODE_REG) && (rm == RM_ESCAPE);

  always_comb begin
    ctl          = '0;
    ctl.dk       = DISP_NONE;
    ctl.is_reg   = (mode == MODE_REG);
    ctl.scale    = sib_scale;
    ctl.idx_sel  = sib_idx;
    ctl.base_sel = use_sib ? sib_base : rm;
    if (use_sib) begin
      ctl.idx_en  = (sib_idx != CODE_NOIDX);
      ctl.base_en = !((mode == MODE_NODISP) && (sib_base == CODE_NOBASE));
    end else if (mode != MODE_REG) begin
      ctl.idx_en  = 1'b0;
      ctl.base_en = !((mode == MODE_NODISP) && (rm == CODE_NOBASE));
    end
    unique case (mode)
      MODE_BYTE:   ctl.dk = DISP_BYTE;
      MODE_WORD:   ctl.dk = DISP_WORD;
      MODE_NODISP: ctl.dk = ctl.base_en ? DISP_NONE : DISP_WORD;
      default:     ctl.dk = DISP_NONE;
    endcase
  end

  // Cross-checks between independently derived control outputs
  always_comb begin
    if (ctl.is_reg) begin
      assert_reg_no_mem_R5: assert (!ctl.base_en && !ctl.idx_en && ctl.dk == DISP_NONE)
        else $error("register operand decoded with memory terms");
    end
    if (!ctl.is_reg && !ctl.base_en) begin
      assert_nobase_word_R8: assert (ctl.dk == DISP_WORD)
        else $error("missing base without a full displacement");
    end
    if (ctl.idx_en) begin
      assert_idx_needs_sib_R7: assert (rm == RM_ESCAPE && sib_idx != CODE_NOIDX)
        else $error("index term enabled outside escape form");
    end
  end

endmodule

// File: rtl/agu_regread.sv
module agu_regread #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS*DATA_W-1:0] file_flat,
  input  logic [SEL_W-1:0]           sel,
  output logic [DATA_W-1:0]          data
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_slice
      assign regs[g] = file_flat[g*DATA_W +: DATA_W];
    end
  endgenerate

  assign data = regs[sel];

endmodule

// File: rtl/agu_sum.sv
module agu_sum
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic              base_en,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic              idx_en,
  input  logic [1:0]        scale,
  input  logic [ADDR_W-1:0] disp_raw,
  input  disp_kind_e        dk,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] idx_term;
  logic [ADDR_W-1:0] disp_term;

  assign base_term = base_en ? base_val : '0;
  assign idx_term  = idx_en ? (idx_val << scale) : '0;

  always_comb begin
    unique case (dk)
      DISP_BYTE: disp_term = {{(ADDR_W-BYTE_W){disp_raw[BYTE_W-1]}}, disp_raw[BYTE_W-1:0]};
      DISP_WORD: disp_term = disp_raw;
      default:   disp_term = '0;
    endcase
  end

  // Three-operand add, carries beyond ADDR_W discarded (modulo wrap)
  assign addr = base_term + idx_term + disp_term;

endmodule

// File: rtl/agu_stage.sv
module agu_stage
  import agu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_GPR  = 8,
  localparam int SEL_W   = $clog2(NUM_GPR),
  localparam int FLAT_W  = NUM_GPR * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [2:0]        in_rm,
  input  logic [7:0]        in_sib,
  input  logic [ADDR_W-1:0] in_disp,
  input  logic [FLAT_W-1:0] gpr_flat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_is_reg,
  output logic [2:0]        out_rm
);

  agu_ctl_t          ctl;
  logic [ADDR_W-1:0] base_val;
  logic [ADDR_W-1:0] idx_val;
  logic [ADDR_W-1:0] sum_addr;
  logic              accept;

  agu_decode u_decode (
    .mode (in_mode),
    .rm   (in_rm),
    .sib  (in_sib),
    .ctl  (ctl)
  );

  agu_regread #(.NUM_REGS(NUM_GPR), .DATA_W(ADDR_W)) u_rd_base (
    .file_flat (gpr_flat),
    .sel       (SEL_W'(ctl.base_sel)),
    .data      (base_val)
  );

  agu_regread #(.NUM_REGS(NUM_GPR), .DATA_W(ADDR_W)) u_rd_idx (
    .file_flat (gpr_flat),
    .sel       (SEL_W'(ctl.idx_sel)),
    .data      (idx_val)
  );

  agu_sum #(.ADDR_W(ADDR_W)) u_sum (
    .base_val (base_val),
    .base_en  (ctl.base_en),
    .idx_val  (idx_val),
    .idx_en   (ctl.idx_en),
    .scale    (ctl.scale),
    .disp_raw (in_disp),
    .dk       (ctl.dk),
    .addr     (sum_addr)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr   <= '0;
      out_is_reg <= 1'b0;
      out_rm     <= '0;
    end else if (accept) begin
      out_addr   <= ctl.is_reg ? '0 : sum_addr;
      out_is_reg <= ctl.is_reg;
      out_rm     <= in_rm;
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_is_reg) && $stable(out_rm)))
    else $error("held result changed during stall");

  assert_accept_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid)
    else $error("accepted request not presented next cycle");

  assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready)
    else $error("empty stage refuses input");

  assert_reg_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_reg) |-> (out_addr == '0))
    else $error("register operand with nonzero address");

endmodule

// File: tb/agu_stage_tb.sv
`timescale 1ns/1ps
module agu_stage_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [1:0]   in_mode;
  logic [2:0]   in_rm;
  logic [7:0]   in_sib;
  logic [31:0]  in_disp;
  logic [255:0] gpr_flat;
  logic         out_valid;
  logic         out_ready;
  logic [31:0]  out_addr;
  logic         out_is_reg;
  logic [2:0]   out_rm;

  logic [31:0]  gpr [8];
  int           n_checks = 0;
  int           n_errors = 0;
  bit           done = 0;

  logic [35:0]  exp_q [$];
  string        tag_q [$];
  bit           have_hold = 0;
  logic [35:0]  hold_val;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) gpr_flat[32*i +: 32] = gpr[i];
  end

  agu_stage u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_mode (in_mode), .in_rm (in_rm), .in_sib (in_sib), .in_disp (in_disp),
    .gpr_flat (gpr_flat),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_addr (out_addr), .out_is_reg (out_is_reg), .out_rm (out_rm)
  );

  function automatic logic [35:0] model(logic [1:0] m, logic [2:0] r, logic [7:0] s, logic [31:0] d);
    logic [31:0] d8, base, idx, dd;
    d8 = {{24{d[7]}}, d[7:0]};
    if (m == 2'b11) return {1'b1, r, 32'h0};
    idx = 32'h0;
    if (r != 3'b100) begin
      base = (m == 2'b00 && r == 3'b101) ? 32'h0 : gpr[r];
      dd = (m == 2'b00) ? ((r == 3'b101) ? d : 32'h0) : (m == 2'b01) ? d8 : d;
    end else begin
      if (s[5:3] != 3'b100) idx = gpr[s[5:3]] * (32'd1 << s[7:6]);
      base = (m == 2'b00 && s[2:0] == 3'b101) ? 32'h0 : gpr[s[2:0]];
      dd = (m == 2'b00) ? ((s[2:0] == 3'b101) ? d : 32'h0) : (m == 2'b01) ? d8 : d;
    end
    return {1'b0, r, base + idx + dd};
  endfunction

  function automatic string classify(logic [1:0] m, logic [2:0] r, logic [7:0] s);
    if (m == 2'b11) return "R5";
    if (r == 3'b100) begin
      if (s[5:3] == 3'b100) return "R7";
      if (m == 2'b00 && s[2:0] == 3'b101) return "R8";
      return "R6";
    end
    if (m == 2'b00) return (r == 3'b101) ? "R4" : "R1";
    return (m == 2'b01) ? "R2" : "R3";
  endfunction

  task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual is_reg=%0b rm=%0d addr=%08h expected is_reg=%0b rm=%0d addr=%08h",
               tag, act[35], act[34:32], act[31:0], exp[35], exp[34:32], exp[31:0]);
    end
  endtask

  // Called 1 ns after inputs change at a falling edge: evaluates the handshakes
  // that the coming rising edge will perform.
  task automatic observe(string force_tag);
    logic [35:0] act;
    string t;
    #1;
    act = {out_is_reg, out_rm, out_addr};
    if (have_hold) check("R10 stall hold", {out_valid, act[34:0]}, {1'b1, hold_val[34:0]});
    if (have_hold) check("R10 stall hold", act, hold_val);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R10 unexpected result", act, 36'h0);
      else begin
        t = tag_q.pop_front();
        check(t, act, exp_q.pop_front());
      end
    end
    have_hold = out_valid && !out_ready;
    hold_val  = act;
    if (in_valid && in_ready) begin
      exp_q.push_back(model(in_mode, in_rm, in_sib, in_disp));
      t = (force_tag != "") ? force_tag : classify(in_mode, in_rm, in_sib);
      tag_q.push_back(t);
    end
  endtask

  task automatic send(string tag, logic [1:0] m, logic [2:0] r, logic [7:0] s, logic [31:0] d);
    bit taken;
    taken = 0;
    while (!taken) begin
      in_valid = 1'b1; in_mode = m; in_rm = r; in_sib = s; in_disp = d; out_ready = 1'b1;
      taken = in_ready;
      observe(tag);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) begin
      observe("");
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_mode = '0; in_rm = '0; in_sib = '0; in_disp = '0;
    for (int i = 0; i < 8; i++) gpr[i] = 32'h1000 * (i + 1) + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R11 reset out_valid", {35'h0, out_valid}, 36'h0);
    check("R11 reset in_ready", {35'h0, in_ready}, 36'h1);
    @(negedge clk);

    // Directed corner cases
    gpr[3] = 32'h0000_1000;
    send("R1", 2'b00, 3'd3, 8'h00, 32'hFFFF_FFFF);
    gpr[6] = 32'h0000_0200;
    send("R2 negative byte", 2'b01, 3'd6, 8'h00, 32'hFFFF_FF80);
    send("R2 upper bits ignored", 2'b01, 3'd6, 8'h00, 32'hABCD_017F);
    gpr[5] = 32'h0000_0010;
    send("R3", 2'b10, 3'd5, 8'h00, 32'h1234_5678);
    gpr[5] = 32'h5555_5555;
    send("R4 no base", 2'b00, 3'd5, 8'h00, 32'hCAFE_0000);
    send("R5 register operand", 2'b11, 3'd4, 8'hFF, 32'h1111_1111);
    gpr[7] = 32'h0000_0100;
    send("R6 scale4", 2'b00, 3'd4, {2'b10, 3'd7, 3'd3}, 32'h0);
    send("R6 scale8 disp32", 2'b10, 3'd4, {2'b11, 3'd7, 3'd0}, 32'h0000_0003);
    send("R7 no index", 2'b01, 3'd4, {2'b11, 3'b100, 3'd1}, 32'h0000_0005);
    send("R8 no base", 2'b00, 3'd4, {2'b00, 3'd0, 3'b101}, 32'h0000_0100);
    send("R8 mode01 uses reg5", 2'b01, 3'd4, {2'b00, 3'd0, 3'b101}, 32'h0000_0001);
    gpr[0] = 32'hFFFF_FFF0;
    send("R9 wrap", 2'b10, 3'd0, 8'h00, 32'h0000_0020);
    gpr[1] = 32'h8000_0000;
    send("R9 wrap scaled", 2'b00, 3'd4, {2'b01, 3'd1, 3'd0}, 32'h0);
    drain();
    check("R10 queue empty after drain", {4'h0, 32'(exp_q.size())}, 36'h0);

    // Random traffic with random back-pressure
    for (int c = 0; c < 6000; c++) begin
      if ($urandom % 8 == 0) begin
        for (int i = 0; i < 8; i++)
          gpr[i] = ($urandom % 4 == 0) ? 32'hFFFF_FFFF - ($urandom % 16) : $urandom;
      end
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 3) != 0;
      in_mode   = 2'($urandom);
      case ($urandom % 4)
        0:       in_rm = 3'b100;
        1:       in_rm = 3'b101;
        default: in_rm = 3'($urandom);
      endcase
      in_sib  = 8'($urandom);
      if ($urandom % 4 == 0) in_sib[2:0] = 3'b101;
      if ($urandom % 4 == 0) in_sib[5:3] = 3'b100;
      in_disp = $urandom;
      observe("");
      @(negedge clk);
    end
    drain();
    check("R10 all results delivered", {4'h0, 32'(exp_q.size())}, 36'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule